// File: doc/BRIEF.md
# Split-Carry Binary Counter

This block is a wide, free-running up-counter that never needs one carry path across its whole width. The count is held in two segments. The low segment advances on every cycle in which the count enable is high. When it rolls over, that event is captured in a single carry flop. The high segment then advances on the following cycle. This breaks the longest ripple path at the segment boundary.

Because the high segment lags by one cycle, the low segment's value is also passed through a one-cycle delay register before the two are joined. The joined output word is therefore always coherent. It equals what an ordinary single-chain counter would have shown one cycle earlier. A consumer can sample the output at any cycle, for example to take a lap time while counting continues, and never sees a torn word. Width and split point are parameters; the default is 32 bits split 16 + 16.

Top module: `split_carry_counter`

## Requirements
- R1: After each rising edge with reset low, `count_o` equals the number of rising edges since reset at which `en` was sampled high, modulo 2^WIDTH, excluding the most recent edge. The output lags a plain counter by exactly one cycle.
- R2: At the rising edge after `rst` is sampled high, `count_o` becomes zero. After reset is released, an `en` sampled high at the first edge first shows on `count_o` one edge later.
- R3: The upper segment of `count_o` (bits WIDTH-1 down to LO_W; 31:16 by default) changes only in the cycle in which the lower segment of `count_o` steps from all ones to zero. In that cycle the upper segment rises by exactly one.
- R4: When the count is all ones and `en` is sampled high, the following output sequence goes from all ones to zero with no intermediate value. For example, an 8-bit instance goes 0xFF then 0x00.
- R5: An `en` sampled low leaves `count_o` unchanged one edge later. A carry already captured from a lower-segment rollover is applied to the upper segment exactly once, even if `en` has gone low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable, sampled every rising edge |
| count_o | output | WIDTH | Registered, aligned count word |

## Verification
Every result of this block is due one rising edge after the stimulus that causes it. An enable sampled at edge k shows in `count_o` after edge k+1. Reset shows after the edge that samples it. The carry between segments becomes visible in the same edge as the low segment's wrap.

The bench drives `en` and `rst` at the falling edge. At each falling edge it advances its own reference counter using the enable it drove at the previous rising edge. It compares `count_o` against the reference value from one step earlier, so every comparison lands exactly where the one-cycle lag places the result.

A second, 8-bit instance with a 4 + 4 split lets the full-width wrap be reached within the run.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;
  // default geometry of the split counter
  localparam int unsigned SCC_WIDTH = 32;
  localparam int unsigned SCC_LO_W  = 16;
endpackage

// File: rtl/scc_lo_seg.sv
`timescale 1ns/1ps
// Low segment: counts enabled cycles and registers its own rollover.
module scc_lo_seg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] lo_q,
  output logic         carry_q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= en & (&lo_q);
      if (en) lo_q <= lo_q + ONE;
    end
  end
endmodule

// File: rtl/scc_hi_seg.sv
`timescale 1ns/1ps
// High segment: advances once per registered carry pulse.
module scc_hi_seg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  output logic [W-1:0] hi_q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)         hi_q <= '0;
    else if (step_i) hi_q <= hi_q + ONE;
  end
endmodule

// File: rtl/scc_delay.sv
`timescale 1ns/1ps
// Resettable register pipeline used to realign the low segment.
module scc_delay #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_pipe
      logic [W-1:0] stage_q [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_st
        always_ff @(posedge clk) begin
          if (rst)         stage_q[i] <= '0;
          else if (i == 0) stage_q[i] <= d_i;
          else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/split_carry_counter.sv
`timescale 1ns/1ps
// Two-segment counter with a registered inter-segment carry.
module split_carry_counter #(
  parameter int unsigned WIDTH = scc_pkg::SCC_WIDTH,
  parameter int unsigned LO_W  = scc_pkg::SCC_LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] count_o
);
  localparam int unsigned HI_W    = WIDTH - LO_W;
  // the carry register adds one cycle to the high segment; match it
  localparam int unsigned ALIGN_N = 1;

  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_dly;
  logic [HI_W-1:0] hi_q;
  logic            carry_q;

  scc_lo_seg #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .en(en), .lo_q(lo_q), .carry_q(carry_q)
  );

  scc_hi_seg #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .step_i(carry_q), .hi_q(hi_q)
  );

  scc_delay #(.W(LO_W), .STAGES(ALIGN_N)) u_align (
    .clk(clk), .rst(rst), .d_i(lo_q), .q_o(lo_dly)
  );

  assign count_o = {hi_q, lo_dly};
endmodule

// File: rtl/scc_chk.sv
`timescale 1ns/1ps
// Property checker for split_carry_counter.
module scc_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LO_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] count_o,
  input logic [LO_W-1:0]  lo_q,
  input logic             carry_q
);
  // edges seen with reset low, saturating; gates looks into the past
  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)              seen_q <= '0;
    else if (seen_q != 3) seen_q <= seen_q + 2'd1;
  end

  // R1: output advances by the enable sampled two edges back
  a_r1_lagged_count: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 3) |-> count_o == $past(count_o) + {{(WIDTH-1){1'b0}}, $past(en, 2)});

  // R2: reset clears the output word
  a_r2_reset_zero: assert property (@(posedge clk)
    rst |=> count_o == '0);

  // R3: upper segment changes only on a lower-segment wrap
  a_r3_upper_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 3 && count_o[WIDTH-1:LO_W] != $past(count_o[WIDTH-1:LO_W]))
      |-> (count_o[LO_W-1:0] == '0 && $past(count_o[LO_W-1:0]) == '1));

  // R3: a carry pulse comes only from an enabled all-ones low segment
  a_r3_carry_source: assert property (@(posedge clk) disable iff (rst)
    carry_q |-> ($past(en) && $past(lo_q) == '1));

  // R5: a carry is a single-cycle pulse, so it is applied once
  a_r5_carry_once: assert property (@(posedge clk) disable iff (rst)
    carry_q |=> !carry_q);

  // R5: disabled cycles freeze the output one edge later
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 3 && !$past(en, 2)) |-> $stable(count_o));
endmodule

bind split_carry_counter scc_chk #(.WIDTH(WIDTH), .LO_W(LO_W)) u_scc_chk (
  .clk(clk), .rst(rst), .en(en), .count_o(count_o),
  .lo_q(lo_q), .carry_q(carry_q)
);

// File: tb/test_split_carry_counter.sv
`timescale 1ns/1ps
module test_split_carry_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [31:0] cnt_w;
  logic [7:0]  cnt_n;

  always #2.5 clk = ~clk;   // 200 MHz

  split_carry_counter i_split_carry_counter (
    .clk(clk), .rst(rst), .en(en), .count_o(cnt_w)
  );

  split_carry_counter #(.WIDTH(8), .LO_W(4)) i_split_carry_counter_narrow (
    .clk(clk), .rst(rst), .en(en), .count_o(cnt_n)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [31:0] ref_w = '0, exp_w = '0;
  logic [7:0]  ref_n = '0, exp_n = '0;

  task automatic check(input logic [31:0] act, input logic [31:0] want, input string tag);
    n_vec++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s: count_o=%h expected %h", tag, act, want);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // one clock: drive en, step the reference model, compare at falling edge
  task automatic tick(input logic e, input string tag);
    logic [31:0] prev_w;
    logic [7:0]  prev_n;
    string tw, tn;
    en = e;
    @(posedge clk);
    @(negedge clk);
    prev_w = exp_w;
    prev_n = exp_n;
    if (rst) begin
      ref_w = '0; exp_w = '0; ref_n = '0; exp_n = '0;
    end else begin
      exp_w = ref_w; ref_w = ref_w + {31'b0, e};
      exp_n = ref_n; ref_n = ref_n + {7'b0, e};
    end
    tw = tag;
    tn = tag;
    if (!rst && prev_w[15:0] == 16'hFFFF && exp_w[15:0] == 16'h0000) tw = "R3";
    if (!rst && prev_n == 8'hFF && exp_n == 8'h00) tn = "R4";
    check(cnt_w, exp_w, tw);
    check({24'b0, cnt_n}, {24'b0, exp_n}, tn);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R2: reset state and first-enable latency
    rst = 1'b1;
    repeat (3) tick(1'b0, "R2");
    @(negedge clk);
    rst = 1'b0;
    tick(1'b1, "R2");   // expect 0: first enable not yet visible
    tick(1'b0, "R2");   // expect 1
    tick(1'b0, "R2");   // still 1

    // R1: random enable patterns
    for (int i = 0; i < 400; i++) tick(($urandom_range(0, 9) < 7), "R1");

    // R4 / R5 on the narrow instance: wrap, then pending carry with en low
    while (ref_n != 8'hFF) tick(1'b1, "R1");
    tick(1'b1, "R4");
    repeat (3) tick(1'b0, "R5");

    // R5 on the narrow instance: low-segment rollover then enable drops
    while (ref_n[3:0] != 4'hF) tick(1'b1, "R1");
    tick(1'b1, "R5");
    repeat (3) tick(1'b0, "R5");

    // R3 / R5 on the wide instance: lower-half wrap, then enable drops
    while (ref_w[15:0] != 16'hFFFF) tick(1'b1, "R1");
    tick(1'b1, "R3");
    repeat (3) tick(1'b0, "R5");
    check({16'b0, cnt_w[31:16]}, {16'b0, ref_w[31:16]}, "R5");

    // R1: sparse enables after the wrap
    for (int i = 0; i < 200; i++) tick(($urandom_range(0, 9) < 3), "R1");

    // R2: reset from a nonzero count
    @(negedge clk);
    rst = 1'b1;
    tick(1'b1, "R2");
    tick(1'b1, "R2");
    @(negedge clk);
    rst = 1'b0;
    tick(1'b0, "R2");
    tick(1'b0, "R2");

    summary();
    $finish;
  end
endmodule